// File: doc/BRIEF.md
# Input-First Separable Allocator

This block pairs requesters with resources once per cycle. Switch allocation in a router is a typical use: input ports request output ports. The block takes an N-by-M request matrix and returns an N-by-M grant matrix. The grant is computed in two arbitration rounds. In the first round, one rotating-priority arbiter per requester keeps a single requested resource. In the second round, one rotating-priority arbiter per resource chooses among the requesters whose first-round choice landed on it.

Each arbiter has a registered one-hot priority pointer. An arbiter moves its pointer to the position just past its winner only when that winner ends up in the final grant matrix. A requester whose first-round choice loses in the second round therefore keeps its priority and retries the same resource first. Grants are combinational from the requests. Pointer updates take effect on the next rising clock edge.

Top module: `isf_alloc`

Matrices are flattened row-major: bit `i*M + j` holds requester i and resource j.

## Requirements
- R1: A grant bit g(i,j) is set only when the request bit r(i,j) is also set.
- R2: At most one grant bit is set in any requester row.
- R3: At most one grant bit is set in any resource column.
- R4: In the first round, requester i selects the first requested resource found by searching upward from its pointer and wrapping from M-1 back to 0.
- R5: In the second round, resource j grants the first requester that selected it, searching upward from the resource pointer and wrapping from N-1 back to 0.
- R6: The pointers of a requester and a resource move to one past each other's index only when g(i,j) is set. A requester whose selection loses keeps its pointer.
- R7: An all-zero request matrix gives an all-zero grant matrix and leaves every pointer unchanged.
- R8: After a synchronous active-high reset, every pointer holds index 0.
- R9: The grant for a request matrix appears in the same cycle. A pointer change first affects the grant in the cycle after the clock edge.
- R10: Every requester with any request selects a resource in the first round, and every resource selected by at least one requester issues a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; pointers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N*M | Request matrix, bit i*M+j = requester i wants resource j |
| gnt | output | N*M | Grant matrix in the same layout |

## Verification
Grants are combinational, so the expected matrix for a request pattern is due in the cycle in which that pattern is applied. The bench drives each pattern on the falling edge and compares the outputs 2 ns later, before the next rising edge. Pointer movement has its effect one edge later. The reference model therefore updates its integer pointers only after each comparison, which matches the registered state that the next pattern will see. Directed patterns cover reset priority, lost selections, all-zero cycles and single requests. A long pseudo-random run then compares every cycle.

// File: rtl/isf_alloc_pkg.sv
package isf_alloc_pkg;
  localparam int unsigned DEF_REQS = 4;
  localparam int unsigned DEF_RSCS = 3;

  // one-hot rotate left by one: the position just past a one-hot winner
  function automatic logic [31:0] rotl1(input logic [31:0] v, input int unsigned w);
    logic [31:0] r;
    r = '0;
    for (int unsigned b = 0; b < w; b++) begin
      r[(b + 1) % w] = v[b];
    end
    return r;
  endfunction
endpackage

// File: rtl/rot_arbiter.sv
module rot_arbiter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req,
  input  logic         upd,
  output logic [W-1:0] gnt
);
  import isf_alloc_pkg::*;

  logic [W-1:0] ptr_q;
  logic [31:0]  nxt_wide;

  // carry chain walked twice so low indices wrap after the highest
  always_comb begin
    logic carry;
    logic c_in;
    carry = 1'b0;
    gnt   = '0;
    for (int k = 0; k < 2 * W; k++) begin
      c_in = carry | ((k < W) ? ptr_q[k % W] : 1'b0);
      if (req[k % W] && c_in) gnt[k % W] = 1'b1;
      carry = c_in & ~req[k % W];
    end
  end

  always_comb nxt_wide = rotl1(32'(gnt), W);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= W'(1);
    end else if (upd && (|gnt)) begin
      ptr_q <= nxt_wide[W-1:0];
    end
  end

  p_gnt_in_req_r1: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  p_gnt_single_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  p_work_cons_r10: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|gnt));
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!upd) |=> $stable(ptr_q));
  p_ptr_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot(ptr_q));
endmodule

// File: rtl/isf_in_stage.sv
module isf_in_stage #(
  parameter int unsigned N = 4,
  parameter int unsigned M = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*M-1:0] req,
  input  logic [N-1:0]   won,
  output logic [N*M-1:0] sel
);
  for (genvar i = 0; i < N; i++) begin : g_row
    rot_arbiter #(.W(M)) u_arb (
      .clk (clk),
      .rst (rst),
      .req (req[i*M +: M]),
      .upd (won[i]),
      .gnt (sel[i*M +: M])
    );
  end
endmodule

// File: rtl/isf_out_stage.sv
module isf_out_stage #(
  parameter int unsigned N = 4,
  parameter int unsigned M = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*M-1:0] sel,
  output logic [N*M-1:0] gnt
);
  for (genvar j = 0; j < M; j++) begin : g_col
    logic [N-1:0] col_req;
    logic [N-1:0] col_gnt;
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign col_req[i]     = sel[i*M + j];
      assign gnt[i*M + j]   = col_gnt[i];
    end
    rot_arbiter #(.W(N)) u_arb (
      .clk (clk),
      .rst (rst),
      .req (col_req),
      .upd (|col_gnt),
      .gnt (col_gnt)
    );
  end
endmodule

// File: rtl/isf_alloc.sv
module isf_alloc #(
  parameter int unsigned N = isf_alloc_pkg::DEF_REQS,
  parameter int unsigned M = isf_alloc_pkg::DEF_RSCS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*M-1:0] req,
  output logic [N*M-1:0] gnt
);
  localparam int unsigned CELLS = N * M;

  logic [CELLS-1:0] sel;
  logic [N-1:0]     row_won;

  isf_in_stage #(.N(N), .M(M)) u_in (
    .clk (clk),
    .rst (rst),
    .req (req),
    .won (row_won),
    .sel (sel)
  );

  isf_out_stage #(.N(N), .M(M)) u_out (
    .clk (clk),
    .rst (rst),
    .sel (sel),
    .gnt (gnt)
  );

  for (genvar i = 0; i < N; i++) begin : g_won
    assign row_won[i] = |gnt[i*M +: M];
    p_row_one_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt[i*M +: M]));
    p_row_served_r10: assert property (@(posedge clk) disable iff (rst)
      (|req[i*M +: M]) |-> (|sel[i*M +: M]));
  end

  for (genvar j = 0; j < M; j++) begin : g_colchk
    logic [N-1:0] gcol;
    for (genvar i = 0; i < N; i++) begin : g_b
      assign gcol[i] = gnt[i*M + j];
    end
    p_col_one_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gcol));
  end

  p_grant_req_r1: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  p_zero_in_r7: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (gnt == '0));
endmodule

// File: tb/isf_alloc_tb.sv
module isf_alloc_tb_top;
  localparam int N = 4;
  localparam int M = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*M-1:0] req = '0;
  logic [N*M-1:0] gnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int iptr [N];
  int optr [M];

  always #5 clk = ~clk;

  isf_alloc #(.N(N), .M(M)) dut_i (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
  );

  function automatic logic [N*M-1:0] model(input logic [N*M-1:0] r);
    int sel [N];
    logic [N*M-1:0] e;
    e = '0;
    for (int i = 0; i < N; i++) begin
      sel[i] = -1;
      for (int k = 0; k < M; k++) begin
        int j;
        j = (iptr[i] + k) % M;
        if (r[i*M + j] && sel[i] < 0) sel[i] = j;
      end
    end
    for (int j = 0; j < M; j++) begin
      int win;
      win = -1;
      for (int k = 0; k < N; k++) begin
        int i;
        i = (optr[j] + k) % N;
        if (sel[i] == j && win < 0) win = i;
      end
      if (win >= 0) e[win*M + j] = 1'b1;
    end
    return e;
  endfunction

  task automatic advance(input logic [N*M-1:0] e);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++)
        if (e[i*M + j]) begin
          iptr[i] = (j + 1) % M;
          optr[j] = (i + 1) % N;
        end
  endtask

  task automatic check(input string tag, input logic [N*M-1:0] act,
                       input logic [N*M-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [N*M-1:0] r);
    logic [N*M-1:0] e;
    @(negedge clk);
    req = r;
    #2;
    e = model(r);
    check(tag, gnt, e);
    if (((gnt & ~r) != '0)) begin
      checks++; fails++;
      $display("FAIL R1: gnt=%b req=%b expected subset", gnt, r);
    end
    advance(e);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) iptr[i] = 0;
    for (int j = 0; j < M; j++) optr[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: after reset all-ones request gives only g(0,0)
    step("R8 reset priority", '1);
    // R4 R5 R6 R9: pointers rotate, following cycles differ
    step("R6 rotate 1", '1);
    step("R6 rotate 2", '1);
    step("R9 rotate 3", '1);
    // R7: zero matrix yields zero and keeps pointers
    step("R7 zero", '0);
    step("R7 zero again", '0);
    step("R7 state kept", '1);
    // R1 R4: single requests at corners
    step("R1 single 0,0", 12'b000000000001);
    step("R1 single 3,2", 12'b100000000000);
    step("R4 row wrap", 12'b000000000101);
    // R6: two rows contend for resource 1, loser keeps pointer
    step("R6 contend", 12'b000000010010);
    step("R6 contend retry", 12'b000000010010);
    step("R5 column wrap", 12'b001001001001);
    step("R10 full diag", 12'b100010001000);
    lfsr = 16'hACE1;
    for (int c = 0; c < 400; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R2 R3 R10 random", lfsr[N*M-1:0] & ((c % 7 == 0) ? '0 : '1));
    end
    @(negedge clk);
    finish_up();
  end
endmodule